// File: doc/BRIEF.md
# USB device address latch

This block keeps the address a full-speed USB device answers to, together with its enable flag. A local microcontroller reaches it through a command interface. A command strobe carries an 8-bit opcode. Write and read opcodes each move one data byte, and the local data bus may be 8 or 16 bits wide.

The byte the firmware writes goes into a shadow register that firmware can read back. The address used on the bus is held in a separate effective register. The shadow value reaches the effective register only after the host acknowledges the zero-length status packet that follows a Set Address request. A USB bus reset forces the effective side to address zero with the device enabled, and leaves the shadow register alone.

The packet decoder gives the block a token address and receives a match flag.

Top module: `usb_addr_latch`

## Requirements
- R1: After power-on reset (`rst_n` low), `dev_en` is 0, `dev_addr` is 0, and a read returns 0.
- R2: A command strobe with opcode 0xB6 stores the low data byte in the shadow register and marks a write as pending. Bit 7 of that byte is the enable flag and bits 6..0 are the address.
- R3: A command strobe with opcode 0xB7 returns the shadow byte on `cmd_rdata` in the next cycle, with `cmd_rvalid` high for that one cycle. Bit 7 is the stored enable and bits 6..0 are the stored address.
- R4: A write does not change `dev_addr` or `dev_en`. Only a later acknowledge does.
- R5: When `stat_ack` is high and a write is pending, the shadow enable and address appear on `dev_en` and `dev_addr` in the next cycle, and the pending mark clears. A second acknowledge then has no effect.
- R6: `stat_ack` with no pending write changes nothing.
- R7: `bus_rst` sets `dev_addr` to 0 and `dev_en` to 1 in the next cycle and clears the pending mark. The shadow register keeps its value.
- R8: When `bus_rst` and `stat_ack` are high in the same cycle, the bus reset wins.
- R9: With a 16-bit data bus, bits 15..8 of a write are ignored and read back as 0.
- R10: `tok_match` is 1 exactly when `dev_en` is 1 and `tok_addr` equals `dev_addr`.
- R11: A command strobe with any other opcode changes neither register and raises no `cmd_rvalid`.
- R12: A write and an acknowledge in the same cycle behave as follows. The acknowledge applies the previous shadow value if a write was already pending. The new byte is stored and stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| cmd_stb | input | 1 | Command strobe |
| cmd_op | input | 8 | Command opcode |
| cmd_wdata | input | BUS_W | Write data |
| cmd_rdata | output | BUS_W | Read data |
| cmd_rvalid | output | 1 | Read data valid |
| bus_rst | input | 1 | USB bus reset pulse |
| stat_ack | input | 1 | Host acknowledged the zero-length IN packet |
| tok_addr | input | 7 | Address field of the received token |
| dev_addr | output | 7 | Effective device address |
| dev_en | output | 1 | Effective device enable |
| tok_match | output | 1 | Token address matches an enabled device |

## Verification
The hardest cases to reach are cycles where several events coincide. One is a bus reset landing together with an acknowledge while a write is pending. Another is a write and an acknowledge sharing a cycle, where the previous and the new shadow byte must be kept apart.

Directed sequences set up each of these collisions explicitly. A long random run then drives bus reset and acknowledge at high rates against frequent writes, so many more overlaps occur naturally. A reference model in the bench follows every cycle.

// File: rtl/usb_addr_latch.sv
module usb_addr_latch #(
  parameter int BUS_W = 16,
  parameter logic [7:0] OP_WR = 8'hB6,
  parameter logic [7:0] OP_RD = 8'hB7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_stb,
  input  logic [7:0]       cmd_op,
  input  logic [BUS_W-1:0] cmd_wdata,
  output logic [BUS_W-1:0] cmd_rdata,
  output logic             cmd_rvalid,
  input  logic             bus_rst,
  input  logic             stat_ack,
  input  logic [6:0]       tok_addr,
  output logic [6:0]       dev_addr,
  output logic             dev_en,
  output logic             tok_match
);
  localparam int RW = 8;

  logic [RW-1:0] shadow;
  logic          pending;
  logic          wr, rd, apply;

  assign wr    = cmd_stb && cmd_op == OP_WR;
  assign rd    = cmd_stb && cmd_op == OP_RD;
  assign apply = stat_ack && pending && !bus_rst;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shadow  <= '0;
      pending <= 1'b0;
    end else begin
      if (wr) shadow <= cmd_wdata[RW-1:0];
      if (wr) pending <= 1'b1;
      else if (bus_rst || stat_ack) pending <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dev_addr <= '0;
      dev_en   <= 1'b0;
    end else if (bus_rst) begin
      dev_addr <= '0;
      dev_en   <= 1'b1;
    end else if (apply) begin
      dev_addr <= shadow[6:0];
      dev_en   <= shadow[7];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmd_rdata  <= '0;
      cmd_rvalid <= 1'b0;
    end else begin
      cmd_rvalid <= rd;
      if (rd) cmd_rdata <= BUS_W'(shadow);
    end

  assign tok_match = dev_en && tok_addr == dev_addr;
endmodule

module usb_addr_latch_chk #(
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_stb,
  input logic [7:0]       cmd_op,
  input logic [BUS_W-1:0] cmd_rdata,
  input logic             cmd_rvalid,
  input logic             bus_rst,
  input logic             stat_ack,
  input logic [6:0]       dev_addr,
  input logic             dev_en,
  input logic [7:0]       shadow
);
  p_busrst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> dev_addr == 7'd0 && dev_en);
  p_shadow_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst && !cmd_stb |=> $stable(shadow));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rst && !stat_ack |=> $stable(dev_addr) && $stable(dev_en));
  p_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb && cmd_op == 8'hB7 |=> cmd_rvalid && cmd_rdata[7:0] == $past(shadow));
  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rvalid |-> (cmd_rdata >> 8) == '0);
  p_other_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb && cmd_op != 8'hB6 && cmd_op != 8'hB7 |=> !cmd_rvalid && $stable(shadow));
endmodule

bind usb_addr_latch usb_addr_latch_chk #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_op(cmd_op),
  .cmd_rdata(cmd_rdata), .cmd_rvalid(cmd_rvalid), .bus_rst(bus_rst),
  .stat_ack(stat_ack), .dev_addr(dev_addr), .dev_en(dev_en), .shadow(shadow));

// File: tb/tb_usb_addr_latch.sv
module tb_usb_addr_latch;
  localparam int BUS_W = 16;

  logic clk = 0, rst_n = 0;
  logic cmd_stb = 0, bus_rst = 0, stat_ack = 0;
  logic [7:0] cmd_op = 0;
  logic [BUS_W-1:0] cmd_wdata = 0, cmd_rdata;
  logic cmd_rvalid, dev_en, tok_match;
  logic [6:0] tok_addr = 0, dev_addr;

  int compared = 0, mismatched = 0;
  bit done = 0;

  logic [7:0] m_sh = 0;
  logic [6:0] m_addr = 0;
  logic m_en = 0, m_pend = 0;

  usb_addr_latch #(.BUS_W(BUS_W)) dut (.*);

  always #5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_match(logic [6:0] t);
    return m_en && t == m_addr;
  endfunction

  task automatic step(bit stb, logic [7:0] op, logic [15:0] wd, bit br, bit ak, logic [6:0] ta);
    bit is_wr, is_rd;
    logic [7:0] old_sh;
    @(negedge clk);
    cmd_stb = stb; cmd_op = op; cmd_wdata = wd; bus_rst = br; stat_ack = ak; tok_addr = ta;
    @(posedge clk);
    is_wr = stb && op == 8'hB6;
    is_rd = stb && op == 8'hB7;
    old_sh = m_sh;
    if (br) begin m_addr = 0; m_en = 1; end
    else if (ak && m_pend) begin m_addr = old_sh[6:0]; m_en = old_sh[7]; end
    if (is_wr) begin m_sh = wd[7:0]; m_pend = 1; end
    else if (br || ak) m_pend = 0;
    #2;
    chk("R4/R5/R7 dev_addr", 32'(dev_addr), 32'(m_addr));
    chk("R4/R5/R7 dev_en", 32'(dev_en), 32'(m_en));
    chk("R10 tok_match", 32'(tok_match), 32'(exp_match(ta)));
    chk("R3/R11 cmd_rvalid", 32'(cmd_rvalid), 32'(is_rd));
    if (is_rd) chk("R3/R9 cmd_rdata", 32'(cmd_rdata), {24'd0, old_sh});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #2;
    chk("R1 dev_en", 32'(dev_en), 0);
    chk("R1 dev_addr", 32'(dev_addr), 0);
    rst_n = 1;
    step(1, 8'hB7, 0, 0, 0, 0);                  // R1 read zero
    step(1, 8'hB6, 16'hA5_85, 0, 0, 7'h05);      // R2 R9 upper byte ignored
    step(1, 8'hB7, 0, 0, 0, 7'h05);              // R3 R9
    step(0, 0, 0, 0, 0, 7'h05);                  // R4 not yet applied
    step(0, 0, 0, 0, 1, 7'h05);                  // R5 apply
    step(0, 0, 0, 0, 0, 7'h05);                  // R10 match
    step(1, 8'hB6, 16'h00_13, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0);                      // R7 bus reset clears pending
    step(0, 0, 0, 0, 1, 0);                      // R6 ack without pending
    step(1, 8'hB7, 0, 0, 0, 0);                  // R7 shadow kept
    step(1, 8'hB6, 16'h00_9A, 0, 0, 0);
    step(0, 0, 0, 1, 1, 7'h1A);                  // R8 bus reset wins
    step(0, 0, 0, 0, 1, 7'h1A);                  // R8 pending gone
    step(1, 8'hB6, 16'h00_C1, 0, 0, 0);
    step(1, 8'hB6, 16'h00_C2, 0, 1, 7'h41);      // R12 old shadow applied, new pending
    step(0, 0, 0, 0, 1, 7'h42);                  // R12 new applied
    step(1, 8'h3C, 16'h00_FF, 0, 0, 0);          // R11 other opcode
    step(1, 8'hB7, 0, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 9);
      logic [7:0] op = (r < 4) ? 8'hB6 : (r < 7) ? 8'hB7 : 8'($urandom);
      logic [6:0] ta = ($urandom_range(0, 1) != 0) ? m_addr : 7'($urandom);
      step($urandom_range(0, 2) != 0, op, 16'($urandom),
           $urandom_range(0, 9) == 0, $urandom_range(0, 3) == 0, ta);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule